// File: doc/BRIEF.md
# Dual-Lane ADC Frame Reader

This block sits on the host side of a dual simultaneous-sampling converter. The converter returns its two channel results over a serial link. The link has one active-low chip select and one serial clock, both driven by this block and shared by both channels. Each channel has its own serial data return line. A single `start` pulse runs one frame, as follows:

- Chip select falls and is held through a programmable setup window.
- The serial clock toggles at a programmable division of the system clock.
- Both return lines are captured on the same rising serial-clock edges.
- Chip select rises again, and a programmable acquisition gap is enforced before the next frame can start.

Each frame carries two leading zero bits, then the sample MSB first. The block discards the two leading bits and builds two signed two's-complement words, which it presents with a one-cycle valid strobe. An early-abort request ends the frame short. The bits already received are kept, the missing low bits read as zero, and a partial flag and a count of captured data bits go out with the result.

Top module: `dual_adc_reader`

## Requirements
- R1: While reset is asserted and after it is released, `csN` and `sclk` are high and `busy` and `resultValid` are low until a `start` is accepted.
- R2: After `start` is accepted, `csN` goes low and stays low with `sclk` high for exactly `SETUP_CYC` system clock cycles before the first `sclk` falling edge.
- R3: Each `sclk` low phase and high phase lasts `CLK_DIV` system clock cycles. A frame that is not aborted has exactly `RES+2` rising `sclk` edges while `csN` is low, and `sclk` is high whenever `csN` is high.
- R4: Both data lines are sampled at every rising `sclk` edge. Rising edges 3 to `RES+2` carry the sample MSB first. `resultA` is built from `sdoA` and `resultB` from `sdoB`, independently.
- R5: Results are two's-complement words of width `RES`, with bit `RES-1` as the sign. `resultValid` is a one-cycle pulse in the cycle where `csN` rises. The results stay unchanged until the next frame ends.
- R6: The values on the data lines during the first two rising edges have no effect on the results.
- R7: If `abortReq` is high while `csN` is low, `csN` rises at the next clock edge and `resultValid` pulses with `partial` = 1. `bitCount` then equals the number of data bits captured (rising edges seen minus 2, floored at 0), the captured bits sit at the top of each result, and all lower bits are 0.
- R8: An abort before any data bit is received (during setup, or within the first two rising edges) gives `bitCount` = 0 and both results 0.
- R9: After `csN` rises, it stays high for at least `ACQ_CYC` cycles, and `busy` stays high for that time. A `start` pulse seen while `busy` is high is ignored and does not start a later frame.
- R10: A frame that completes without abort reports `partial` = 0 and `bitCount` = `RES`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one frame (taken only while not busy) |
| abortReq | input | 1 | Request early end of the current frame |
| sdoA | input | 1 | Serial return line of channel A |
| sdoB | input | 1 | Serial return line of channel B |
| csN | output | 1 | Active-low frame select to the converter |
| sclk | output | 1 | Serial clock to the converter, idles high |
| busy | output | 1 | Frame or acquisition gap in progress |
| resultValid | output | 1 | One-cycle strobe for new results |
| resultA | output | RES | Channel A signed result |
| resultB | output | RES | Channel B signed result |
| partial | output | 1 | Last result came from an aborted frame |
| bitCount | output | $clog2(RES+1) | Data bits captured in the last frame |

## Verification
The hardest case to reach from the ports is an abort that lands exactly between two chosen rising `sclk` edges. The outcome depends on how many data bits have landed, and an abort just past the two lead bits must still give an all-zero result. The bench models the converter: it places the next bit on each `sclk` falling edge and counts rising edges while `csN` is low. It raises `abortReq` for one cycle once a chosen edge count is reached, which places the abort in the high phase after that edge. Driving ones during the lead bits on some frames shows that the leading positions are discarded.

// File: rtl/dualadc_pkg.sv
package dualadc_pkg;

  // Count of zero bits that precede the sample on each data line.
  localparam int LEAD_BITS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_ACQ
  } frameState_t;

  // Strobes from the frame sequencer to the lane datapath.
  typedef struct packed {
    logic clear;    // new frame: wipe captured bits and counters
    logic sample;   // a rising serial-clock edge happens at this clock edge
    logic finish;   // frame ends at this clock edge: publish results
    logic aborted;  // qualifies finish: frame ended short
  } laneCtrl_t;

endpackage

// File: rtl/dualadc_ctrl.sv
module dualadc_ctrl
  import dualadc_pkg::*;
#(
  parameter int RES       = 14,
  parameter int CLK_DIV   = 2,
  parameter int SETUP_CYC = 3,
  parameter int ACQ_CYC   = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      abortReq,
  output logic      csN,
  output logic      sclk,
  output logic      busy,
  output laneCtrl_t laneCtrl
);

  localparam int TOTAL_RISES = RES + LEAD_BITS;
  localparam int RISE_W      = $clog2(TOTAL_RISES + 1);
  localparam int WAIT_MAX1   = (CLK_DIV > SETUP_CYC) ? CLK_DIV : SETUP_CYC;
  localparam int WAIT_MAX    = (WAIT_MAX1 > ACQ_CYC) ? WAIT_MAX1 : ACQ_CYC;
  localparam int TIM_W       = $clog2(WAIT_MAX + 1);

  localparam logic [TIM_W-1:0]  SETUP_LAST = TIM_W'(SETUP_CYC - 1);
  localparam logic [TIM_W-1:0]  HALF_LAST  = TIM_W'(CLK_DIV - 1);
  localparam logic [TIM_W-1:0]  ACQ_LAST   = TIM_W'(ACQ_CYC - 1);
  localparam logic [RISE_W-1:0] RISE_FULL  = RISE_W'(TOTAL_RISES);

  frameState_t       state, stateNext;
  logic [TIM_W-1:0]  timer, timerNext;
  logic [RISE_W-1:0] riseCnt, riseNext;
  logic              allRises;

  assign allRises = (riseCnt == RISE_FULL);

  always_comb begin
    stateNext = state;
    timerNext = timer + 1'b1;
    riseNext  = riseCnt;
    laneCtrl  = '0;
    unique case (state)
      ST_IDLE: begin
        timerNext = '0;
        if (start) begin
          stateNext      = ST_SETUP;
          riseNext       = '0;
          laneCtrl.clear = 1'b1;
        end
      end
      ST_SETUP: begin
        if (abortReq) begin
          stateNext        = ST_ACQ;
          timerNext        = '0;
          laneCtrl.finish  = 1'b1;
          laneCtrl.aborted = 1'b1;
        end else if (timer == SETUP_LAST) begin
          stateNext = ST_LOW;
          timerNext = '0;
        end
      end
      ST_LOW: begin
        if (abortReq) begin
          stateNext        = ST_ACQ;
          timerNext        = '0;
          laneCtrl.finish  = 1'b1;
          laneCtrl.aborted = 1'b1;
        end else if (timer == HALF_LAST) begin
          stateNext       = ST_HIGH;
          timerNext       = '0;
          riseNext        = riseCnt + 1'b1;
          laneCtrl.sample = 1'b1;
        end
      end
      ST_HIGH: begin
        if (abortReq || (allRises && timer == HALF_LAST)) begin
          stateNext        = ST_ACQ;
          timerNext        = '0;
          laneCtrl.finish  = 1'b1;
          laneCtrl.aborted = !allRises;
        end else if (timer == HALF_LAST) begin
          stateNext = ST_LOW;
          timerNext = '0;
        end
      end
      ST_ACQ: begin
        if (timer == ACQ_LAST) begin
          stateNext = ST_IDLE;
          timerNext = '0;
        end
      end
      default: begin
        stateNext = ST_IDLE;
        timerNext = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      timer   <= '0;
      riseCnt <= '0;
      csN     <= 1'b1;
      sclk    <= 1'b1;
      busy    <= 1'b0;
    end else begin
      state   <= stateNext;
      timer   <= timerNext;
      riseCnt <= riseNext;
      csN     <= !(stateNext inside {ST_SETUP, ST_LOW, ST_HIGH});
      sclk    <= (stateNext != ST_LOW);
      busy    <= (stateNext != ST_IDLE);
    end
  end

endmodule

// File: rtl/dualadc_lanes.sv
module dualadc_lanes
  import dualadc_pkg::*;
#(
  parameter int RES   = 14,
  parameter int LANES = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  laneCtrl_t                      laneCtrl,
  input  logic [LANES-1:0]               sdo,
  output logic [LANES-1:0][RES-1:0]      result,
  output logic                           resultValid,
  output logic                           partial,
  output logic [$clog2(RES+1)-1:0]       bitCount
);

  localparam int CNT_W  = $clog2(RES + 1);
  localparam int IDX_W  = (RES > 1) ? $clog2(RES) : 1;
  localparam int LEAD_W = $clog2(LEAD_BITS + 1);

  logic [LEAD_W-1:0] leadCnt;
  logic [CNT_W-1:0]  dataCnt;
  logic              takeBit;
  logic [IDX_W-1:0]  bitPos;

  // A rising edge carries data only once the lead bits are gone and the
  // word is not yet full; edges past the word are dropped.
  assign takeBit = laneCtrl.sample && (leadCnt == LEAD_W'(LEAD_BITS))
                   && (dataCnt < CNT_W'(RES));
  assign bitPos  = IDX_W'(RES - 1) - IDX_W'(dataCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leadCnt <= '0;
      dataCnt <= '0;
    end else if (laneCtrl.clear) begin
      leadCnt <= '0;
      dataCnt <= '0;
    end else if (laneCtrl.sample) begin
      if (leadCnt != LEAD_W'(LEAD_BITS)) begin
        leadCnt <= leadCnt + 1'b1;
      end else if (takeBit) begin
        dataCnt <= dataCnt + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [RES-1:0] capture;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        capture <= '0;
      end else if (laneCtrl.clear) begin
        capture <= '0;
      end else if (takeBit) begin
        capture[bitPos] <= sdo[g];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        result[g] <= '0;
      end else if (laneCtrl.finish) begin
        result[g] <= capture;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      partial     <= 1'b0;
      bitCount    <= '0;
    end else begin
      resultValid <= laneCtrl.finish;
      if (laneCtrl.finish) begin
        partial  <= laneCtrl.aborted;
        bitCount <= dataCnt;
      end
    end
  end

endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader
  import dualadc_pkg::*;
#(
  parameter int RES       = 14,
  parameter int CLK_DIV   = 2,
  parameter int SETUP_CYC = 3,
  parameter int ACQ_CYC   = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic                     abortReq,
  input  logic                     sdoA,
  input  logic                     sdoB,
  output logic                     csN,
  output logic                     sclk,
  output logic                     busy,
  output logic                     resultValid,
  output logic [RES-1:0]           resultA,
  output logic [RES-1:0]           resultB,
  output logic                     partial,
  output logic [$clog2(RES+1)-1:0] bitCount
);

  localparam int LANES = 2;

  laneCtrl_t                  laneCtrl;
  logic [LANES-1:0][RES-1:0]  laneResult;

  dualadc_ctrl #(
    .RES      (RES),
    .CLK_DIV  (CLK_DIV),
    .SETUP_CYC(SETUP_CYC),
    .ACQ_CYC  (ACQ_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .abortReq(abortReq),
    .csN     (csN),
    .sclk    (sclk),
    .busy    (busy),
    .laneCtrl(laneCtrl)
  );

  dualadc_lanes #(
    .RES  (RES),
    .LANES(LANES)
  ) u_lanes (
    .clk        (clk),
    .rstN       (rstN),
    .laneCtrl   (laneCtrl),
    .sdo        ({sdoB, sdoA}),
    .result     (laneResult),
    .resultValid(resultValid),
    .partial    (partial),
    .bitCount   (bitCount)
  );

  assign resultA = laneResult[0];
  assign resultB = laneResult[1];

endmodule

// File: rtl/dual_adc_reader_chk.sv
module dual_adc_reader_chk #(
  parameter int RES       = 14,
  parameter int SETUP_CYC = 3,
  parameter int ACQ_CYC   = 10
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     csN,
  input logic                     sclk,
  input logic                     resultValid,
  input logic                     partial,
  input logic [$clog2(RES+1)-1:0] bitCount
);

  localparam int CW    = $clog2(RES + 1);
  localparam int TOTAL = RES + 2;

  logic [15:0] lowRun, highRun, rises;
  logic        csQ, sclkQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowRun  <= '0;
      highRun <= 16'(ACQ_CYC);
      rises   <= '0;
      csQ     <= 1'b1;
      sclkQ   <= 1'b1;
    end else begin
      csQ   <= csN;
      sclkQ <= sclk;
      if (csN) begin
        lowRun  <= '0;
        rises   <= '0;
        highRun <= (highRun == 16'hFFFF) ? highRun : highRun + 1'b1;
      end else begin
        highRun <= '0;
        lowRun  <= (lowRun == 16'hFFFF) ? lowRun : lowRun + 1'b1;
        if (sclk && !sclkQ) rises <= rises + 1'b1;
      end
    end
  end

  p_setup_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !sclk && sclkQ && csQ == 1'b0) |-> lowRun >= 16'(SETUP_CYC));

  p_idle_clock_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk);

  p_rise_limit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (csN && !csQ) |-> rises <= 16'(TOTAL));

  p_rise_exact_r3: assert property (@(posedge clk) disable iff (!rstN)
    (csN && !csQ && !partial) |-> rises == 16'(TOTAL));

  p_valid_at_cs_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (csN && !csQ));

  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  p_partial_short_r7: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && partial) |-> bitCount < CW'(RES));

  p_acq_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && csQ) |-> highRun >= 16'(ACQ_CYC));

  p_full_count_r10: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !partial) |-> bitCount == CW'(RES));

endmodule

bind dual_adc_reader dual_adc_reader_chk #(
  .RES      (RES),
  .SETUP_CYC(SETUP_CYC),
  .ACQ_CYC  (ACQ_CYC)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .csN        (csN),
  .sclk       (sclk),
  .resultValid(resultValid),
  .partial    (partial),
  .bitCount   (bitCount)
);

// File: tb/dual_adc_reader_bench.sv
module dual_adc_reader_bench;

  localparam int RES   = 14;
  localparam int DIV   = 2;
  localparam int SETUP = 3;
  localparam int ACQ   = 6;
  localparam int CW    = $clog2(RES + 1);
  localparam int NVEC  = 7;

  // Stimulus table: channel A value, channel B value, abort after this
  // many rising edges (-1 = none), drive ones during the lead bits.
  localparam logic [RES-1:0] VEC_A [NVEC] =
    '{14'h1FFF, 14'h3FFF, 14'h2001, 14'h0ABC, 14'h1234, 14'h3FFF, 14'h1111};
  localparam logic [RES-1:0] VEC_B [NVEC] =
    '{14'h2000, 14'h0000, 14'h1555, 14'h3210, 14'h2DCB, 14'h3FFF, 14'h2222};
  localparam int VEC_ABORT [NVEC] = '{-1, -1, -1, 7, 2, 15, 0};
  localparam bit VEC_JUNK  [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, abortReq = 1'b0;
  logic sdoA = 1'b0, sdoB = 1'b0;
  logic csN, sclk, busy, resultValid, partial;
  logic [RES-1:0] resultA, resultB;
  logic [CW-1:0]  bitCount;

  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  dual_adc_reader #(
    .RES(RES), .CLK_DIV(DIV), .SETUP_CYC(SETUP), .ACQ_CYC(ACQ)
  ) u_dual_adc_reader (
    .clk(clk), .rstN(rstN), .start(start), .abortReq(abortReq),
    .sdoA(sdoA), .sdoB(sdoB), .csN(csN), .sclk(sclk), .busy(busy),
    .resultValid(resultValid), .resultA(resultA), .resultB(resultB),
    .partial(partial), .bitCount(bitCount)
  );

  // Converter model: next bit appears on each serial-clock falling edge.
  logic [RES-1:0] devA = '0, devB = '0;
  logic leadJunk = 1'b0;
  int fallCnt = 0, riseSeen = 0;

  function automatic logic bitOf(logic [RES-1:0] v, int k, logic junk);
    if (k <= 2) return junk;
    if (k <= RES + 2) return v[RES-1-(k-3)];
    return 1'b0;
  endfunction

  always @(negedge sclk or negedge csN) begin
    if (sclk) begin
      fallCnt = 0;
      sdoA = leadJunk;
      sdoB = leadJunk;
    end else if (!csN) begin
      fallCnt++;
      sdoA = bitOf(devA, fallCnt, leadJunk);
      sdoB = bitOf(devB, fallCnt, leadJunk);
    end
  end

  always @(posedge sclk) if (!csN) riseSeen++;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitValid();
    for (int n = 0; n < 2000 && !resultValid; n++) @(negedge clk);
  endtask

  task automatic runVector(int idx);
    int n;
    logic [RES-1:0] mask, expA, expB;
    devA = VEC_A[idx];
    devB = VEC_B[idx];
    leadJunk = VEC_JUNK[idx];
    riseSeen = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (VEC_ABORT[idx] == 0) begin
      abortReq = 1'b1;
      @(negedge clk) abortReq = 1'b0;
    end else if (VEC_ABORT[idx] > 0) begin
      for (int w = 0; w < 2000 && riseSeen < VEC_ABORT[idx]; w++) @(negedge clk);
      abortReq = 1'b1;
      @(negedge clk) abortReq = 1'b0;
    end
    waitValid();
    if (VEC_ABORT[idx] < 0) n = RES;
    else if (VEC_ABORT[idx] <= 2) n = 0;
    else n = (VEC_ABORT[idx] - 2 > RES) ? RES : VEC_ABORT[idx] - 2;
    mask = (n == 0) ? '0 : ({RES{1'b1}} << (RES - n));
    expA = VEC_A[idx] & mask;
    expB = VEC_B[idx] & mask;
    check(resultValid === 1'b1 && csN === 1'b1, "R5 valid with cs rise",
          {30'd0, resultValid, csN}, 32'h3);
    check(resultA === expA, (n == RES) ? "R4 lane A word" : "R7 lane A partial word",
          32'(resultA), 32'(expA));
    check(resultB === expB, (n == RES) ? "R4 lane B word" : "R7 lane B partial word",
          32'(resultB), 32'(expB));
    check(partial === (VEC_ABORT[idx] >= 0), "R10/R7 partial flag",
          32'(partial), 32'(VEC_ABORT[idx] >= 0));
    check(bitCount === CW'(n), (n == 0) ? "R8 zero data bits" : "R7 R10 bit count",
          32'(bitCount), 32'(n));
    if (VEC_ABORT[idx] < 0)
      check(riseSeen == RES + 2, "R3 rising edge total", 32'(riseSeen), 32'(RES + 2));
    if (VEC_JUNK[idx] && VEC_ABORT[idx] < 0)
      check(resultA === VEC_A[idx], "R6 lead bits ignored", 32'(resultA), 32'(VEC_A[idx]));
    @(negedge clk);
    check(resultValid === 1'b0, "R5 valid one cycle", 32'(resultValid), 32'h0);
    for (int w = 0; w < 100 && busy; w++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cnt;
    logic [RES-1:0] heldA;
    repeat (3) @(negedge clk);
    check(csN === 1'b1 && sclk === 1'b1 && busy === 1'b0 && resultValid === 1'b0,
          "R1 state in reset", {28'd0, csN, sclk, busy, resultValid}, 32'hC);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(csN === 1'b1 && sclk === 1'b1 && busy === 1'b0 && resultValid === 1'b0,
          "R1 state after reset", {28'd0, csN, sclk, busy, resultValid}, 32'hC);

    for (int i = 0; i < NVEC; i++) runVector(i);

    // Directed: setup window, half periods, acquisition gap.
    devA = 14'h0F0F; devB = 14'h30C3; leadJunk = 1'b0; riseSeen = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cnt = 0;
    while (!csN && sclk && cnt < 100) begin cnt++; @(negedge clk); end
    check(cnt == SETUP, "R2 setup cycles", 32'(cnt), 32'(SETUP));
    cnt = 0;
    while (!sclk && cnt < 100) begin cnt++; @(negedge clk); end
    check(cnt == DIV, "R3 low phase", 32'(cnt), 32'(DIV));
    cnt = 0;
    while (sclk && !csN && cnt < 100) begin cnt++; @(negedge clk); end
    check(cnt == DIV, "R3 high phase", 32'(cnt), 32'(DIV));
    waitValid();
    heldA = resultA;
    start = 1'b1;
    cnt = 0;
    while (csN && cnt < 200) begin cnt++; @(negedge clk); end
    check(cnt >= ACQ, "R9 acquisition gap", 32'(cnt), 32'(ACQ));
    start = 1'b0;
    check(resultA === heldA, "R5 result held", 32'(resultA), 32'(heldA));

    // Start pulses while busy are ignored.
    repeat (5) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    waitValid();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy === 1'b1, "R9 busy in gap", 32'(busy), 32'h1);
    cnt = 0;
    for (int w = 0; w < 4 * ACQ; w++) begin
      @(negedge clk);
      if (!csN) cnt++;
    end
    check(cnt == 0 && busy === 1'b0, "R9 start while busy ignored",
          {cnt[30:0], busy}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule